// File: doc/BRIEF.md
# Pseudo-Random Chain Code Generator

This block is a small digital noise source. A four-stage shift register steps once on each enabled clock. Its first stage takes the exclusive-OR of the last two stages. With that feedback the register walks through every nonzero four-bit state before it repeats, so it gives a maximal-length pseudo-random bit stream of period 15. A downstream filter can shape that stream into noise.

The register state is always visible as a parallel word. A run-time tap selector sends any one stage to a serial output. A one-cycle marker flags the seed state, so a consumer can align to the start of each period. A parallel load port writes an arbitrary state. Guard logic keeps the register out of the all-zeros lock-up state. A load of zero is replaced by the seed, and an all-zeros register is reseeded on the next clock.

Top module: `chain_code_gen`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) loads the seed: stage B = 1 and stages A, C, D = 0. On `par_out` this is 4'b0010, with stage A in bit 0, B in bit 1, C in bit 2 and D in bit 3.
- R2: On each clock with `step_en` high and `load_en` low, the new stage A is the XOR of the old stages C and D. B takes old A, C takes old B, and D takes old C.
- R3: With `step_en` and `load_en` both low, the state holds unchanged across clocks.
- R4: Starting from the seed, the state returns to the seed after exactly 15 enabled clocks, and each of the 15 nonzero states is held exactly once per period.
- R5: `par_out` is never all zeros after reset. A parallel load of 4'b0000 puts the seed into the register instead.
- R6: With `load_en` high and a nonzero `load_val`, the register holds `load_val` after the clock edge. This happens whatever the level of `step_en`.
- R7: `ser_out` equals stage number `tap_sel` of the current state (0 = A, 1 = B, 2 = C, 3 = D). It follows changes of `tap_sel` without waiting for a clock.
- R8: `period_mark` is high exactly while the state equals the seed, so under continuous stepping it is high for one clock in every 15.
- R9: Over one full period each stage is 1 in 8 states and 0 in 7 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the seed |
| step_en | input | 1 | Advance the register one step on this clock |
| load_en | input | 1 | Write `load_val` into the register (takes priority over stepping) |
| load_val | input | 4 | State to load; zero is replaced by the seed |
| tap_sel | input | 2 | Stage that drives `ser_out` (0 = A … 3 = D) |
| ser_out | output | 1 | Serial pseudo-random bit from the selected stage |
| par_out | output | 4 | Full register state, stage A in bit 0 |
| period_mark | output | 1 | High while the register holds the seed state |

## Verification
The bench builds the block only with its default of four stages. This keeps the whole period at 15 states, so the bench can walk it exhaustively. It checks every state against an independent model and records that each nonzero state appears exactly once. It also counts the ones on every stage. At this size every tap position, the zero-load replacement and the load-over-step priority can each be driven directly from a known state.

// File: rtl/chain_code_pkg.sv
// Package: chain_code_pkg
// Shared types for the chain code generator.
// Assumes: the next-state action is chosen by one decoder and applied by one register.
package chain_code_pkg;

    // Action applied to the shift register on the next clock edge
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SHIFT  = 2'd1,
        ACT_LOAD   = 2'd2,
        ACT_RESEED = 2'd3
    } step_act_e;

endpackage

// File: rtl/cc_action_sel.sv
// Module: cc_action_sel
// Picks what the shift register does on the next edge.
// Priority: load of a nonzero word, then reseed (zero load or all-zeros state),
// then step, then hold.
// Assumes: the register itself handles reset; this decode is purely combinational.
module cc_action_sel
    import chain_code_pkg::*;
#(
    parameter int STAGES = 4
) (
    input  logic              step_en,
    input  logic              load_en,
    input  logic [STAGES-1:0] load_val,
    input  logic [STAGES-1:0] state,
    output step_act_e         act
);

    logic load_is_zero;
    logic state_is_zero;

    // Detect the forbidden all-zeros word on the load port and in the register
    always_comb begin
        load_is_zero  = (load_val == '0);
        state_is_zero = (state == '0);
    end

    // Resolve the action by fixed priority
    always_comb begin
        if (load_en && !load_is_zero)
            act = ACT_LOAD;
        else if ((load_en && load_is_zero) || state_is_zero)
            act = ACT_RESEED;
        else if (step_en)
            act = ACT_SHIFT;
        else
            act = ACT_HOLD;
    end

endmodule

// File: rtl/cc_shift_reg.sv
// Module: cc_shift_reg
// State register of the generator. A shift moves each stage to the next one
// and feeds the first stage with the XOR of the last two stages.
// Assumes: the action comes from cc_action_sel; STAGES >= 3 and
// the feedback is maximal for the chosen length.
module cc_shift_reg
    import chain_code_pkg::*;
#(
    parameter int              STAGES = 4,
    parameter logic [STAGES-1:0] SEED = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_act_e         act,
    input  logic [STAGES-1:0] load_val,
    output logic [STAGES-1:0] state
);

    logic fb;

    // Feedback bit from the penultimate and last stage
    always_comb fb = state[STAGES-1] ^ state[STAGES-2];

    // Register update: reset seed, load, reseed, shift or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            case (act)
                ACT_LOAD:   state <= load_val;
                ACT_RESEED: state <= SEED;
                ACT_SHIFT:  state <= {state[STAGES-2:0], fb};
                default:    state <= state;
            endcase
        end
    end

    // R1
    reset_seed_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> state == SEED);

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_SHIFT |=> (state[STAGES-1:1] == $past(state[STAGES-2:0]))
                          && (state[0] == ($past(state[STAGES-1]) ^ $past(state[STAGES-2]))));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> $stable(state));

    // R6
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_LOAD |=> state == $past(load_val));

endmodule

// File: rtl/cc_tap_mux.sv
// Module: cc_tap_mux
// Routes one selected stage of the state to the serial output.
// Assumes: sel is below STAGES; the selection is combinational.
module cc_tap_mux #(
    parameter int STAGES = 4,
    parameter int SEL_W  = 2
) (
    input  logic [STAGES-1:0] state,
    input  logic [SEL_W-1:0]  sel,
    output logic              bit_out
);

    logic [STAGES-1:0] hit;

    // One-hot decode of the selector, one AND term per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_tap
        always_comb hit[g] = (sel == SEL_W'(g)) && state[g];
    end

    // OR the terms together into the serial bit
    always_comb bit_out = |hit;

endmodule

// File: rtl/chain_code_gen.sv
// Module: chain_code_gen
// Top level of the maximal-length chain code generator: action decode,
// shift register, serial tap and the period-start marker.
// Assumes: a single clock; reset is synchronous and active low.
module chain_code_gen
    import chain_code_pkg::*;
#(
    parameter int STAGES = 4,
    localparam int SEL_W = $clog2(STAGES),
    localparam logic [STAGES-1:0] SEED = STAGES'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load_en,
    input  logic [STAGES-1:0] load_val,
    input  logic [SEL_W-1:0]  tap_sel,
    output logic              ser_out,
    output logic [STAGES-1:0] par_out,
    output logic              period_mark
);

    step_act_e         act;
    logic [STAGES-1:0] state;

    cc_action_sel #(.STAGES(STAGES)) u_act (
        .step_en  (step_en),
        .load_en  (load_en),
        .load_val (load_val),
        .state    (state),
        .act      (act)
    );

    cc_shift_reg #(.STAGES(STAGES), .SEED(SEED)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .load_val (load_val),
        .state    (state)
    );

    cc_tap_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_tap (
        .state   (state),
        .sel     (tap_sel),
        .bit_out (ser_out)
    );

    // Parallel output and seed-state marker
    always_comb begin
        par_out     = state;
        period_mark = (state == SEED);
    end

    // R5
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out != '0);

    // R5
    zero_load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && load_val == '0 |=> period_mark);

    // R8
    mark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_mark && step_en && !load_en |=> !period_mark);

endmodule

// File: tb/chain_code_gen_test.sv
module chain_code_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [1:0] tap_sel = 2'd0;
    logic       ser_out;
    logic [3:0] par_out;
    logic       period_mark;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] m;

    always #5 clk = ~clk;

    chain_code_gen uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
        .load_val(load_val), .tap_sel(tap_sel), .ser_out(ser_out),
        .par_out(par_out), .period_mark(period_mark)
    );

    // reference step from R2: A<=C^D, B<=A, C<=B, D<=C
    function automatic logic [3:0] adv(input logic [3:0] s);
        return {s[2], s[1], s[0], s[2] ^ s[3]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step_en = 1'b1;
        tick(); tick();
        chk("R1 reset seed", par_out, 4'b0010);
        chk("R8 mark at seed", period_mark, 1);
        rst_n = 1'b1; step_en = 1'b0;
        m = 4'b0010;
    endtask

    task automatic t_period();
        logic [15:0] seen = '0;
        int ones[4] = '{0, 0, 0, 0};
        step_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            chk("R4 no repeat", int'(seen[par_out]), 0);
            seen[par_out] = 1'b1;
            for (int k = 0; k < 4; k++) ones[k] += int'(par_out[k]);
            tick();
            m = adv(m);
            chk("R2 step", par_out, m);
            chk("R8 mark", period_mark, (i == 14) ? 1 : 0);
        end
        step_en = 1'b0;
        chk("R4 all nonzero visited", seen, 16'hFFFE);
        chk("R4 back at seed", par_out, 4'b0010);
        for (int k = 0; k < 4; k++) chk("R9 ones per stage", ones[k], 8);
    endtask

    task automatic t_hold();
        step_en = 1'b1;
        tick(); m = adv(m);
        tick(); m = adv(m);
        step_en = 1'b0;
        tick(); tick(); tick();
        chk("R3 hold", par_out, m);
    endtask

    task automatic t_taps();
        for (int s = 0; s < 5; s++) begin
            for (int t = 0; t < 4; t++) begin
                tap_sel = 2'(t);
                #1;
                chk("R7 tap", ser_out, m[t]);
            end
            step_en = 1'b1; tick(); m = adv(m); step_en = 1'b0;
        end
    endtask

    task automatic t_load();
        load_en = 1'b1; load_val = 4'd9; step_en = 1'b0;
        tick(); m = 4'd9;
        chk("R6 load", par_out, 9);
        load_val = 4'd6; step_en = 1'b1;
        tick(); m = 4'd6;
        chk("R6 load over step", par_out, 6);
        load_en = 1'b0;
        tick(); m = adv(m);
        chk("R2 step after load", par_out, m);
        step_en = 1'b0;
    endtask

    task automatic t_load_zero();
        load_en = 1'b1; load_val = 4'd0; step_en = 1'b1;
        tick();
        load_en = 1'b0; step_en = 1'b0;
        chk("R5 zero load gives seed", par_out, 4'b0010);
        chk("R8 mark after zero load", period_mark, 1);
        tick();
        chk("R5 stays nonzero", int'(par_out != 4'd0), 1);
        m = 4'b0010;
    endtask

    task automatic t_mid_reset();
        step_en = 1'b1;
        tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid-run reset", par_out, 4'b0010);
        rst_n = 1'b1; step_en = 1'b0;
        m = 4'b0010;
    endtask

    initial begin
        #1;
        t_reset();
        t_period();
        t_hold();
        t_taps();
        t_load();
        t_load_zero();
        t_period();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule